// File: doc/BRIEF.md
# Frame-Aware Receive Byte Queue

This block is the receive queue between a serial frame receiver and a host register port. The receiver pushes two kinds of byte: payload bytes, and a status byte that closes each frame and holds that frame's error flags. Every stored entry carries a ninth tag bit that marks it as a status byte. Because of this tag, the queue can tell the host how many bytes to read before it reaches the end of the oldest frame. The host pops bytes from a show-ahead head. The host also raises a strobe whenever it reads the queue's status register.

The queue reports three things. The first is a frame-aware byte count, with an end-of-frame indicator. The second is a sticky fill-level flag, whose threshold the host programs. The third is an overrun flag. When a byte arrives at a full queue, the newest stored entry is replaced by an overrun status byte. After that, input is dropped until the host has serviced the overrun and a new frame starts. Both sides run on one clock.

Top module: `rxq_frame_fifo`

## Requirements
- R1: The queue holds DEPTH (64) entries. After 64 accepted writes with no reads, the count reads 64 and the overrun flag stays low.
- R2: While no status entry is stored, q_eof is low and q_count equals the number of stored entries. An empty queue gives q_count 0 and q_eof low.
- R3: While at least one status entry is stored, q_eof is high and q_count equals the number of entries from the head up to and including the oldest status entry. Writes made behind that entry leave q_count unchanged.
- R4: Each pop lowers q_count by one. The head entry read while q_count is 1 and q_eof is high carries the tag (rd_is_status = 1).
- R5: Once the oldest status entry is popped, q_count gives the distance to the next status entry if there is one. Otherwise it gives the total number of entries left.
- R6: rx_full sets on any cycle in which the stored total moves from below fill_level to at or above it, with fill_level nonzero. It clears on sr_read. It sets again when a write raises the total back to the level after a pop lowered it.
- R7: A write that is accepted while 64 entries are stored and no pop occurs replaces the newest entry with tag 1 and byte 0x20 (bit 5 = overrun), whatever that entry was. The total stays at 64 and ovr_flag rises.
- R8: While ovr_flag is high, writes are dropped. ovr_flag falls in the cycle after both an sr_read and a pop have been seen since the overrun. Writes then stay dropped until a cycle with wr_sof high, and the write made in that cycle is stored.
- R9: An sr_read strobe leaves q_count, q_eof and the head entry unchanged.
- R10: A write and a pop in the same cycle leave the total unchanged, even with 64 entries stored, and do not cause an overrun.
- R11: A pop request while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Receiver write strobe |
| wr_data | input | 8 | Byte to store |
| wr_is_status | input | 1 | Byte is a frame status byte |
| wr_sof | input | 1 | Pulse: a new frame begins |
| rd_en | input | 1 | Host pop of the head entry |
| rd_data | output | 8 | Head entry byte (show-ahead) |
| rd_is_status | output | 1 | Head entry tag |
| sr_read | input | 1 | Host read of the status register |
| fill_level | input | 6 | Fill threshold for rx_full, 0 disables |
| q_count | output | 7 | Frame-aware byte count |
| q_eof | output | 1 | A status entry is stored |
| rx_full | output | 1 | Sticky fill-level flag |
| ovr_flag | output | 1 | Overrun condition active |

## Verification
The assertions assume that rd_en and sr_read are single-cycle strobes sampled on the rising edge. They also assume that the host holds fill_level steady while the flag is being observed. The stimulus changes every input at the falling edge. It drops each strobe after one cycle and programs fill_level only right after reset. It never pops more entries than q_count and q_eof announce, except in the deliberate empty-pop case.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned OVR_BIT = 5;

  typedef struct packed {
    logic       is_stat;
    logic [7:0] val;
  } rxq_entry_t;

  function automatic rxq_entry_t ovr_entry();
    rxq_entry_t e;
    e.is_stat = 1'b1;
    e.val = '0;
    e.val[OVR_BIT] = 1'b1;
    return e;
  endfunction

  function automatic logic fill_reached(input int unsigned total, input int unsigned level);
    return (level != 0) && (total >= level);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             ovr_event,
  input  rxq_entry_t       wr_entry,
  output rxq_entry_t       head,
  output logic [DEPTH-1:0] tag_vec,
  output logic [AW-1:0]    rptr,
  output logic [CW-1:0]    total,
  output logic [CW-1:0]    total_nxt,
  output logic [CW-1:0]    stat_cnt
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] last_idx;
  logic          last_was_stat;

  assign last_idx      = wptr - AW'(1);
  assign last_was_stat = tag_vec[last_idx];
  assign head          = mem[rptr];
  assign total_nxt     = total + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_entry;
    else if (ovr_event) mem[last_idx] <= ovr_entry();
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      total    <= '0;
      stat_cnt <= '0;
      tag_vec  <= '0;
    end else begin
      total <= total_nxt;
      stat_cnt <= stat_cnt
                + CW'(push && wr_entry.is_stat)
                + CW'(ovr_event && !last_was_stat)
                - CW'(pop && head.is_stat);
      if (pop) begin
        tag_vec[rptr] <= 1'b0;
        rptr <= rptr + AW'(1);
      end
      if (push) begin
        tag_vec[wptr] <= wr_entry.is_stat;
        wptr <= wptr + AW'(1);
      end else if (ovr_event) begin
        tag_vec[last_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxq_tracker.sv
module rxq_tracker #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic [DEPTH-1:0] tag_vec,
  input  logic [AW-1:0]    rptr,
  input  logic [CW-1:0]    total,
  input  logic [CW-1:0]    stat_cnt,
  output logic [CW-1:0]    q_count,
  output logic             q_eof
);
  // Offset from the head to the oldest tagged entry; lowest offset wins.
  function automatic logic [AW-1:0] first_off(input logic [DEPTH-1:0] tv,
                                              input logic [AW-1:0] base);
    logic [AW-1:0] off;
    off = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (tv[base + AW'(k)]) off = AW'(k);
    end
    return off;
  endfunction

  logic [AW-1:0] off;
  assign off     = first_off(tag_vec, rptr);
  assign q_eof   = (stat_cnt != '0);
  assign q_count = q_eof ? (CW'(off) + CW'(1)) : total;
endmodule

// File: rtl/rxq_ovr_ctl.sv
module rxq_ovr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic wr_sof,
  input  logic sr_read,
  input  logic pop,
  input  logic is_full,
  output logic push,
  output logic ovr_event,
  output logic ovr_flag
);
  logic hold, sr_seen, pop_seen, accept;

  assign accept    = wr_valid && (!hold || (wr_sof && !ovr_flag));
  assign ovr_event = accept && is_full && !pop;
  assign push      = accept && !ovr_event;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      hold     <= 1'b0;
      sr_seen  <= 1'b0;
      pop_seen <= 1'b0;
    end else if (ovr_event) begin
      ovr_flag <= 1'b1;
      hold     <= 1'b1;
      sr_seen  <= 1'b0;
      pop_seen <= 1'b0;
    end else if (ovr_flag) begin
      if ((sr_seen || sr_read) && (pop_seen || pop)) ovr_flag <= 1'b0;
      sr_seen  <= sr_seen || sr_read;
      pop_seen <= pop_seen || pop;
    end else if (hold && wr_sof) begin
      hold <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_fill_flag.sv
module rxq_fill_flag
  import rxq_pkg::*;
#(
  parameter int CW = 7,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] total_nxt,
  input  logic [FW-1:0] fill_level,
  input  logic          sr_read,
  output logic          rx_full
);
  logic crossing;
  assign crossing = fill_reached(int'(total_nxt), int'(fill_level))
                 && !fill_reached(int'(total), int'(fill_level));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_full <= 1'b0;
    else        rx_full <= (rx_full && !sr_read) || crossing;
  end
endmodule

// File: rtl/rxq_frame_fifo.sv
module rxq_frame_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          wr_is_status,
  input  logic          wr_sof,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_is_status,
  input  logic          sr_read,
  input  logic [AW-1:0] fill_level,
  output logic [CW-1:0] q_count,
  output logic          q_eof,
  output logic          rx_full,
  output logic          ovr_flag
);
  logic             push, pop, ovr_event, is_full;
  logic [DEPTH-1:0] tag_vec;
  logic [AW-1:0]    rptr;
  logic [CW-1:0]    total, total_nxt, stat_cnt;
  rxq_entry_t       head, wr_entry;

  assign pop          = rd_en && (total != '0);
  assign is_full      = (total == CW'(DEPTH));
  assign wr_entry     = '{is_stat: wr_is_status, val: wr_data};
  assign rd_data      = head.val;
  assign rd_is_status = head.is_stat;

  rxq_ovr_ctl u_ovr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sof(wr_sof),
    .sr_read(sr_read), .pop(pop), .is_full(is_full),
    .push(push), .ovr_event(ovr_event), .ovr_flag(ovr_flag)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .ovr_event(ovr_event),
    .wr_entry(wr_entry), .head(head), .tag_vec(tag_vec), .rptr(rptr),
    .total(total), .total_nxt(total_nxt), .stat_cnt(stat_cnt)
  );

  rxq_tracker #(.DEPTH(DEPTH)) u_track (
    .tag_vec(tag_vec), .rptr(rptr), .total(total), .stat_cnt(stat_cnt),
    .q_count(q_count), .q_eof(q_eof)
  );

  rxq_fill_flag #(.CW(CW), .FW(AW)) u_fill (
    .clk(clk), .rst_n(rst_n), .total(total), .total_nxt(total_nxt),
    .fill_level(fill_level), .sr_read(sr_read), .rx_full(rx_full)
  );
endmodule

// File: rtl/rxq_frame_fifo_chk.sv
module rxq_frame_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             rd_en,
  input logic             sr_read,
  input logic             rd_is_status,
  input logic [CW-1:0]    q_count,
  input logic             q_eof,
  input logic             ovr_flag,
  input logic             push,
  input logic             pop,
  input logic             ovr_event,
  input logic [CW-1:0]    total,
  input logic [CW-1:0]    stat_cnt,
  input logic [DEPTH-1:0] tag_vec
);
  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (total <= CW'(DEPTH)) && (q_count <= total));
  p_empty_no_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (total == '0) |-> !q_eof);
  p_plain_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !q_eof |-> (q_count == total) && !(total != '0 && rd_is_status));
  p_tags_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tag_vec) == int'(stat_cnt));
  p_status_at_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && q_eof && q_count == CW'(1)) |-> rd_is_status);
  p_ovr_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> ovr_flag && q_eof && (total == CW'(DEPTH)));
  p_drop_while_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !pop) |=> (total == $past(total)));
  p_sr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_read && !wr_valid && !rd_en) |=> $stable(q_count) && $stable(q_eof));
  p_pair_total_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (total == $past(total)));
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && total == '0 && !wr_valid) |=> (total == '0));
endmodule

bind rxq_frame_fifo rxq_frame_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en),
  .sr_read(sr_read), .rd_is_status(rd_is_status), .q_count(q_count),
  .q_eof(q_eof), .ovr_flag(ovr_flag), .push(push), .pop(pop),
  .ovr_event(ovr_event), .total(total), .stat_cnt(stat_cnt), .tag_vec(tag_vec)
);

// File: tb/tb_rxq_frame_fifo.sv
`timescale 1ns/1ps
module tb_rxq_frame_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_is_status = 1'b0, wr_sof = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0, sr_read = 1'b0;
  logic [5:0] fill_level = '0;
  logic [7:0] rd_data;
  logic       rd_is_status, q_eof, rx_full, ovr_flag;
  logic [6:0] q_count;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxq_frame_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_is_status(wr_is_status), .wr_sof(wr_sof), .rd_en(rd_en),
    .rd_data(rd_data), .rd_is_status(rd_is_status), .sr_read(sr_read),
    .fill_level(fill_level), .q_count(q_count), .q_eof(q_eof),
    .rx_full(rx_full), .ovr_flag(ovr_flag)
  );

  // op: 0 idle, 1 write data, 2 write status, 3 pop, 4 status-register read
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] din;
    logic [8:0] head;
    logic [6:0] cnt;
    logic       eof;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 8'h11, 9'h000, 7'd1, 1'b0},
    '{3'd1, 8'h22, 9'h000, 7'd2, 1'b0},
    '{3'd2, 8'h80, 9'h000, 7'd3, 1'b1},
    '{3'd1, 8'h33, 9'h000, 7'd3, 1'b1},
    '{3'd2, 8'h40, 9'h000, 7'd3, 1'b1},
    '{3'd4, 8'h00, 9'h000, 7'd3, 1'b1},
    '{3'd3, 8'h00, 9'h011, 7'd2, 1'b1},
    '{3'd3, 8'h00, 9'h022, 7'd1, 1'b1},
    '{3'd3, 8'h00, 9'h180, 7'd2, 1'b1},
    '{3'd3, 8'h00, 9'h033, 7'd1, 1'b1},
    '{3'd3, 8'h00, 9'h140, 7'd0, 1'b0},
    '{3'd1, 8'h55, 9'h000, 7'd1, 1'b0},
    '{3'd1, 8'h66, 9'h000, 7'd2, 1'b0},
    '{3'd3, 8'h00, 9'h055, 7'd1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive inputs at a falling edge for one rising edge, then release them.
  task automatic cyc(input logic wv, input logic ws, input logic [7:0] d,
                     input logic rd, input logic sr, input logic sof);
    wr_valid = wv; wr_is_status = ws; wr_data = d;
    rd_en = rd; sr_read = sr; wr_sof = sof;
    @(negedge clk);
    wr_valid = 1'b0; wr_is_status = 1'b0; wr_sof = 1'b0;
    rd_en = 1'b0; sr_read = 1'b0;
  endtask

  task automatic do_reset(input logic [5:0] lvl);
    rst_n = 1'b0;
    fill_level = lvl;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill_n(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'(i), 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    do_reset(6'd0);
    chk("R2 reset count", q_count, 0);
    chk("R2 reset eof", q_eof, 0);
    chk("R6 reset rx_full", rx_full, 0);
    chk("R7 reset ovr", ovr_flag, 0);

    // Table walk: R2, R3, R4, R5, R9
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = TBL[v];
      if (t.op == 3'd3)
        chk($sformatf("R4 head vec%0d", v), {rd_is_status, rd_data}, t.head);
      case (t.op)
        3'd1: cyc(1'b1, 1'b0, t.din, 1'b0, 1'b0, 1'b0);
        3'd2: cyc(1'b1, 1'b1, t.din, 1'b0, 1'b0, 1'b0);
        3'd3: cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        3'd4: cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        default: cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      endcase
      chk($sformatf("R3/R5 count vec%0d", v), q_count, t.cnt);
      chk($sformatf("R2/R3 eof vec%0d", v), q_eof, t.eof);
    end

    // R11: pop from empty is ignored
    do_reset(6'd0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R11 empty pop count", q_count, 0);
    cyc(1'b1, 1'b0, 8'hAB, 1'b0, 1'b0, 1'b0);
    chk("R11 head after empty pop", {rd_is_status, rd_data}, 9'h0AB);
    chk("R11 count", q_count, 1);

    // R6 fill flag and R9 quiet status read
    do_reset(6'd4);
    fill_n(3);
    chk("R6 below level", rx_full, 0);
    fill_n(1);
    chk("R6 at level", rx_full, 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R6 cleared by sr_read", rx_full, 0);
    chk("R9 count after sr_read", q_count, 4);
    chk("R9 head after sr_read", {rd_is_status, rd_data}, 9'h000);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R6 stays low after pop", rx_full, 0);
    cyc(1'b1, 1'b0, 8'h09, 1'b0, 1'b0, 1'b0);
    chk("R6 sets again", rx_full, 1);

    // R10: write and pop together at full
    do_reset(6'd0);
    fill_n(64);
    chk("R1 full count", q_count, 64);
    chk("R1 no overrun at 64", ovr_flag, 0);
    cyc(1'b1, 1'b0, 8'hAA, 1'b1, 1'b0, 1'b0);
    chk("R10 count kept", q_count, 64);
    chk("R10 no overrun", ovr_flag, 0);
    chk("R10 head advanced", {rd_is_status, rd_data}, 9'h001);

    // R7 / R8: overrun and recovery
    do_reset(6'd0);
    fill_n(64);
    cyc(1'b1, 1'b0, 8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R7 ovr flag", ovr_flag, 1);
    chk("R7 count", q_count, 64);
    chk("R7 eof", q_eof, 1);
    cyc(1'b1, 1'b0, 8'hDD, 1'b0, 1'b0, 1'b0);
    chk("R8 write dropped", q_count, 64);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R8 sr_read alone keeps ovr", ovr_flag, 1);
    chk("R8 head", {rd_is_status, rd_data}, 9'h000);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R8 ovr cleared", ovr_flag, 0);
    chk("R8 count after pop", q_count, 63);
    cyc(1'b1, 1'b0, 8'h99, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 8'h77, 1'b0, 1'b0, 1'b1);
    chk("R3 count frozen", q_count, 63);
    for (int i = 0; i < 62; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R7 overrun entry", {rd_is_status, rd_data}, 9'h120);
    chk("R4 count one", q_count, 1);
    chk("R4 eof at one", q_eof, 1);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 remaining", q_count, 1);
    chk("R5 eof low", q_eof, 0);
    chk("R8 only frame-start byte kept", {rd_is_status, rd_data}, 9'h077);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R2 drained", q_count, 0);

    finish_run();
  end
endmodule